// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it may accept one 13-bit instruction word together with a valid strobe. It decodes the register-operand arithmetic, logic, move, complement, increment and decrement instructions, plus a few accumulator-only operations. The operand is read from a 64-entry, 8-bit register file and combined with the accumulator. The result is committed on the same clock edge, either to the accumulator or back to the addressed register.

The zero (Z), carry (C) and digit-carry (DC) flags are updated according to a fixed mask for each instruction. Any opcode outside the supported set leaves all state untouched, as does any cycle without the valid strobe. A combinational debug port reads any register-file entry for observation.

Top module: `acc_alu_exec`

## Requirements
- R1: While reset (rstN low) is active, and immediately after it, the accumulator, Z, C, DC and all 64 registers read zero.
- R2: Word layout: bits [12:8] give the group, bits [7:6] the sub-code and bits [5:0] the register address. For groups 1 to 4, and for group 5 with bit 7 at 0, bit 6 picks the destination: 0 writes the accumulator and 1 writes the addressed register. The other destination is left unchanged.
- R3: Add (group 3, bit 7 = 1) computes A+R. C is set to the carry out of bit 7, DC to the carry out of bit 3, and Z to whether the 8-bit result is zero.
- R4: Subtract (group 1, sub-code 00 or 01) computes R−A. C=1 when R ≥ A (no borrow), and DC=1 when R[3:0] ≥ A[3:0]. Z is set from the result.
- R5: OR (group 2, bit 7 = 0), AND (group 2, bit 7 = 1) and XOR (group 3, bit 7 = 0) update Z only. C and DC keep their values.
- R6: Group 4 handles two operations. Sub-codes 00/01 copy R, and sub-codes 10/11 take the one's complement of R. Both update Z only.
- R7: Increment (group 5, sub-codes 00/01) computes R+1. Decrement (group 1, sub-codes 10/11) computes R−1. Both update Z only, and C and DC are unchanged.
- R8: In group 0, word 0x040|r copies A into register r and changes no flag. Word 0x0C0|r clears register r and sets Z. Word 0x080 clears A and sets Z; C and DC are unchanged.
- R9: Word 0x001 decimal-adjusts A in two steps. First, t = A+0x06 if A[3:0] > 9 or DC=1; otherwise t = A. Second, if t[7:4] > 9 or C=1, then A = t+0x60 (mod 256) and C is set; otherwise A = t and C is kept. Z and DC are unchanged.
- R10: Word 0x000, every other unlisted word (for example 0x002, 0x010, 0x020, 0x5A0, 0x1FFF), and any cycle with instrValid low leave the accumulator, the flags and all registers unchanged.
- R11: dbgData shows register dbgAddr combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 13 | Instruction word |
| dbgAddr | input | 6 | Debug read address |
| dbgData | output | 8 | Register file contents at dbgAddr |
| accOut | output | 8 | Accumulator |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / no-borrow flag |
| flagDc | output | 1 | Digit-carry flag |

## Verification
The instruction set has no immediate load, so the hardest states to reach are arbitrary operand values, together with chosen C and DC values, ahead of a decimal adjust. The stimulus builds any accumulator value by shift-and-increment. Each step copies A to a scratch register, adds the scratch register to A to double it, and applies an increment into A for each one bit. The value is then moved to a target register. An add of chosen operands sets C and DC just before the instruction under test. Every intermediate step is compared against an independent model, so the setup sequences also exercise the destination and flag masks.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_PASSA, OP_ZERO, OP_SUB, OP_DEC, OP_OR, OP_AND,
    OP_XOR, OP_ADD, OP_PASSR, OP_COM, OP_INC, OP_DAA
  } aluOp_e;

  typedef struct packed {
    aluOp_e op;
    logic   wrAcc;
    logic   wrReg;
    logic   updZ;
    logic   updC;
    logic   updDc;
  } ctrlStrobe_t;
endpackage

// File: rtl/alu_exec_ctrl.sv
module alu_exec_ctrl
  import alu_exec_pkg::*;
#(
  parameter int INSTR_W = 13,
  parameter int ADDR_W  = 6
) (
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobe_t        strobe
);
  localparam int GRP_W = INSTR_W - ADDR_W - 2;

  logic [GRP_W-1:0]  grp;
  logic [1:0]        subCode;
  logic [ADDR_W-1:0] addrBits;
  logic              toReg;

  assign grp      = instrWord[INSTR_W-1 -: GRP_W];
  assign subCode  = instrWord[ADDR_W+1 -: 2];
  assign addrBits = instrWord[ADDR_W-1:0];
  assign toReg    = instrWord[ADDR_W];

  always_comb begin
    strobe = '0;
    case (grp)
      GRP_W'(0): begin
        if (subCode == 2'b00 && addrBits == ADDR_W'(1)) begin
          strobe.op    = OP_DAA;
          strobe.wrAcc = 1'b1;
          strobe.updC  = 1'b1;
        end else if (subCode == 2'b10 && addrBits == '0) begin
          strobe.op    = OP_ZERO;
          strobe.wrAcc = 1'b1;
          strobe.updZ  = 1'b1;
        end else if (subCode == 2'b01) begin
          strobe.op    = OP_PASSA;
          strobe.wrReg = 1'b1;
        end else if (subCode == 2'b11) begin
          strobe.op    = OP_ZERO;
          strobe.wrReg = 1'b1;
          strobe.updZ  = 1'b1;
        end
      end
      GRP_W'(1): begin
        strobe.op    = subCode[1] ? OP_DEC : OP_SUB;
        strobe.wrAcc = !toReg;
        strobe.wrReg = toReg;
        strobe.updZ  = 1'b1;
        strobe.updC  = !subCode[1];
        strobe.updDc = !subCode[1];
      end
      GRP_W'(2): begin
        strobe.op    = subCode[1] ? OP_AND : OP_OR;
        strobe.wrAcc = !toReg;
        strobe.wrReg = toReg;
        strobe.updZ  = 1'b1;
      end
      GRP_W'(3): begin
        strobe.op    = subCode[1] ? OP_ADD : OP_XOR;
        strobe.wrAcc = !toReg;
        strobe.wrReg = toReg;
        strobe.updZ  = 1'b1;
        strobe.updC  = subCode[1];
        strobe.updDc = subCode[1];
      end
      GRP_W'(4): begin
        strobe.op    = subCode[1] ? OP_COM : OP_PASSR;
        strobe.wrAcc = !toReg;
        strobe.wrReg = toReg;
        strobe.updZ  = 1'b1;
      end
      GRP_W'(5): begin
        if (!subCode[1]) begin
          strobe.op    = OP_INC;
          strobe.wrAcc = !toReg;
          strobe.wrReg = toReg;
          strobe.updZ  = 1'b1;
        end
      end
      default: strobe = '0;
    endcase
    if (!instrValid) strobe = '0;
  end
endmodule

// File: rtl/alu_exec_datapath.sv
module alu_exec_datapath
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic [DATA_W-1:0] accOut,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagDc
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DATA_W / 2;
  localparam logic [DATA_W-1:0] ADJ_LO = DATA_W'(6);
  localparam logic [DATA_W-1:0] ADJ_HI = DATA_W'(6) << HALF;
  localparam logic [HALF-1:0]   NIB_MAX = HALF'(9);

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [DATA_W-1:0] accReg;
  logic [DATA_W-1:0] opR;
  logic [DATA_W-1:0] result;
  logic              cNext;
  logic              dcNext;

  logic [DATA_W:0]   sumFull;
  logic [HALF:0]     sumLo;
  logic [DATA_W:0]   diffFull;
  logic [HALF:0]     diffLo;
  logic [DATA_W-1:0] daaMid;
  logic              daaLoAdj;
  logic              daaHiAdj;

  assign opR     = regFile[regAddr];
  assign dbgData = regFile[dbgAddr];
  assign accOut  = accReg;

  always_comb begin
    sumFull  = {1'b0, opR} + {1'b0, accReg};
    sumLo    = {1'b0, opR[HALF-1:0]} + {1'b0, accReg[HALF-1:0]};
    diffFull = {1'b0, opR} - {1'b0, accReg};
    diffLo   = {1'b0, opR[HALF-1:0]} - {1'b0, accReg[HALF-1:0]};
    daaLoAdj = (accReg[HALF-1:0] > NIB_MAX) || flagDc;
    daaMid   = accReg + (daaLoAdj ? ADJ_LO : '0);
    daaHiAdj = (daaMid[DATA_W-1:HALF] > NIB_MAX) || flagC;
    result   = accReg;
    cNext    = flagC;
    dcNext   = flagDc;
    case (strobe.op)
      OP_PASSA: result = accReg;
      OP_ZERO:  result = '0;
      OP_SUB: begin
        result = diffFull[DATA_W-1:0];
        cNext  = !diffFull[DATA_W];
        dcNext = !diffLo[HALF];
      end
      OP_DEC:   result = opR - DATA_W'(1);
      OP_OR:    result = opR | accReg;
      OP_AND:   result = opR & accReg;
      OP_XOR:   result = opR ^ accReg;
      OP_ADD: begin
        result = sumFull[DATA_W-1:0];
        cNext  = sumFull[DATA_W];
        dcNext = sumLo[HALF];
      end
      OP_PASSR: result = opR;
      OP_COM:   result = ~opR;
      OP_INC:   result = opR + DATA_W'(1);
      OP_DAA: begin
        result = daaMid + (daaHiAdj ? ADJ_HI : '0);
        cNext  = daaHiAdj ? 1'b1 : flagC;
      end
      default:  result = accReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      flagZ  <= 1'b0;
      flagC  <= 1'b0;
      flagDc <= 1'b0;
    end else begin
      if (strobe.wrAcc) accReg <= result;
      if (strobe.updZ)  flagZ  <= (result == '0);
      if (strobe.updC)  flagC  <= cNext;
      if (strobe.updDc) flagDc <= dcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (strobe.wrReg) begin
      regFile[regAddr] <= result;
    end
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import alu_exec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int INSTR_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  dbgAddr,
  output logic [DATA_W-1:0]  dbgData,
  output logic [DATA_W-1:0]  accOut,
  output logic               flagZ,
  output logic               flagC,
  output logic               flagDc
);
  ctrlStrobe_t strobe;

  alu_exec_ctrl #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) ctrl_i (
    .instrValid(instrValid),
    .instrWord (instrWord),
    .strobe    (strobe)
  );

  alu_exec_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .regAddr(instrWord[ADDR_W-1:0]),
    .dbgAddr(dbgAddr),
    .dbgData(dbgData),
    .accOut (accOut),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .flagDc (flagDc)
  );
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [12:0] instrWord,
  input logic [7:0]  accOut,
  input logic        flagZ,
  input logic        flagC,
  input logic        flagDc
);
  logic [4:0] grp;
  assign grp = instrWord[12:8];

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> $stable(accOut) && $stable(flagZ) && $stable(flagC) && $stable(flagDc)); // R10

  AST_TOREG_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && grp >= 5'd1 && grp <= 5'd4 && instrWord[6] |=> $stable(accOut)); // R2

  AST_LOGIC_KEEPS_CDC: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && (grp == 5'd2 || (grp == 5'd3 && !instrWord[7]))
    |=> $stable(flagC) && $stable(flagDc)); // R5

  AST_INCDEC_KEEPS_CDC: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && ((grp == 5'd5 && !instrWord[7]) || (grp == 5'd1 && instrWord[7]))
    |=> $stable(flagC) && $stable(flagDc)); // R7

  AST_MOVRA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && instrWord[12:6] == 7'b0000001
    |=> $stable(accOut) && $stable(flagZ) && $stable(flagC) && $stable(flagDc)); // R8

  AST_CLRA_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && instrWord == 13'h080 |=> accOut == 8'h00 && flagZ); // R8

  AST_DAA_KEEPS_ZDC: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && instrWord == 13'h001 |=> $stable(flagZ) && $stable(flagDc)); // R9
endmodule

bind acc_alu_exec alu_exec_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instrValid(instrValid),
  .instrWord (instrWord),
  .accOut    (accOut),
  .flagZ     (flagZ),
  .flagC     (flagC),
  .flagDc    (flagDc)
);

// File: tb/acc_alu_exec_tb_top.sv
`timescale 1ns/1ps
module acc_alu_exec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [12:0] instrWord = '0;
  logic [5:0]  dbgAddr = '0;
  logic [7:0]  dbgData;
  logic [7:0]  accOut;
  logic        flagZ, flagC, flagDc;

  always #4 clk = ~clk;

  acc_alu_exec dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .accOut(accOut),
    .flagZ(flagZ), .flagC(flagC), .flagDc(flagDc)
  );

  int nChecks = 0;
  int nErrs   = 0;
  bit doneFlag = 0;

  logic [7:0] mAcc;
  logic       mZ, mC, mDc;
  logic [7:0] mRf [64];

  localparam logic [5:0] SCR = 6'd63;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mAcc = 0; mZ = 0; mC = 0; mDc = 0;
    for (int i = 0; i < 64; i++) mRf[i] = 0;
  endtask

  task automatic modelExec(input logic [12:0] w);
    logic [4:0] g; logic [1:0] s; logic [5:0] a; logic [7:0] r, res, t;
    logic toA, toR, uz, uc, udc, nc, ndc;
    g = w[12:8]; s = w[7:6]; a = w[5:0]; r = mRf[a];
    toA = 0; toR = 0; uz = 0; uc = 0; udc = 0; res = 0; nc = mC; ndc = mDc;
    if (g == 0) begin
      if (w == 13'h001) begin
        t = mAcc;
        if (t[3:0] > 9 || mDc) t = t + 8'h06;
        if (t[7:4] > 9 || mC) begin res = t + 8'h60; nc = 1; end
        else res = t;
        toA = 1; uc = 1;
      end else if (w == 13'h080) begin res = 0; toA = 1; uz = 1; end
      else if (s == 2'b01) begin res = mAcc; toR = 1; end
      else if (s == 2'b11) begin res = 0; toR = 1; uz = 1; end
    end else if (g >= 1 && g <= 5 && !(g == 5 && s[1])) begin
      toA = !s[0]; toR = s[0]; uz = 1;
      case (g)
        5'd1: if (!s[1]) begin
                res = r - mAcc; nc = (r >= mAcc); ndc = (r[3:0] >= mAcc[3:0]); uc = 1; udc = 1;
              end else res = r - 8'd1;
        5'd2: res = s[1] ? (r & mAcc) : (r | mAcc);
        5'd3: if (s[1]) begin
                {nc, res} = {1'b0, r} + {1'b0, mAcc};
                ndc = ({1'b0, r[3:0]} + {1'b0, mAcc[3:0]}) > 5'h0F; uc = 1; udc = 1;
              end else res = r ^ mAcc;
        5'd4: res = s[1] ? ~r : r;
        default: res = r + 8'd1;
      endcase
    end
    if (toA) mAcc = res;
    if (toR) mRf[a] = res;
    if (uz) mZ = (res == 0);
    if (uc) mC = nc;
    if (udc) mDc = ndc;
  endtask

  task automatic checkState(input string tag, input logic [5:0] a);
    dbgAddr = a; #1;
    chk(tag, "acc", accOut, mAcc);
    chk(tag, "Z", {7'b0, flagZ}, {7'b0, mZ});
    chk(tag, "C", {7'b0, flagC}, {7'b0, mC});
    chk(tag, "DC", {7'b0, flagDc}, {7'b0, mDc});
    chk(tag, "reg", dbgData, mRf[a]);
  endtask

  task automatic sweepRegs(input string tag);
    for (int i = 0; i < 64; i++) begin
      dbgAddr = 6'(i); #1;
      chk(tag, "regfile", dbgData, mRf[i]);
    end
  endtask

  task automatic issue(input logic [12:0] w, input string tag, input logic vld = 1'b1);
    @(negedge clk);
    instrWord = w; instrValid = vld;
    @(posedge clk);
    @(negedge clk);
    instrValid = 0;
    if (vld) modelExec(w);
    checkState(tag, w[5:0]);
  endtask

  task automatic loadA(input logic [7:0] v);
    issue(13'h080, "R8 setup");
    for (int b = 7; b >= 0; b--) begin
      issue(13'h040 | SCR, "R8 setup");
      issue(13'h380 | SCR, "R3 setup");
      if (v[b]) begin
        issue(13'h040 | SCR, "R8 setup");
        issue(13'h500 | SCR, "R7 setup");
      end
    end
  endtask

  task automatic loadReg(input logic [5:0] a, input logic [7:0] v);
    loadA(v);
    issue(13'h040 | a, "R2 setup");
  endtask

  task automatic t_reset();
    modelReset();
    checkState("R1", 6'd0);
    sweepRegs("R1");
  endtask

  task automatic t_add();
    loadReg(6'd10, 8'h7F); loadA(8'h01);
    issue(13'h380 | 6'd10, "R3");
    chk("R3", "0x7F+0x01", accOut, 8'h80);
    chk("R3", "DC from bit3", {7'b0, flagDc}, 8'h01);
    loadReg(6'd11, 8'hFF); loadA(8'h01);
    issue(13'h3C0 | 6'd11, "R3");
    chk("R3", "0xFF+0x01 into reg", dbgData, 8'h00);
    chk("R3", "carry", {6'b0, flagC, flagZ}, 8'h03);
    chk("R2", "acc kept on reg form", accOut, 8'h01);
  endtask

  task automatic t_sub();
    loadReg(6'd12, 8'h05); loadA(8'h07);
    issue(13'h100 | 6'd12, "R4");
    chk("R4", "0x05-0x07", accOut, 8'hFE);
    chk("R4", "borrow C=0", {7'b0, flagC}, 8'h00);
    loadReg(6'd13, 8'h30); loadA(8'h21);
    issue(13'h140 | 6'd13, "R4");
    chk("R4", "0x30-0x21", dbgData, 8'h0F);
    chk("R4", "C=1 DC=0", {6'b0, flagC, flagDc}, 8'h02);
    loadReg(6'd14, 8'h44); loadA(8'h44);
    issue(13'h100 | 6'd14, "R4");
    chk("R4", "equal gives Z C DC", {5'b0, flagZ, flagC, flagDc}, 8'h07);
  endtask

  task automatic t_logic();
    loadReg(6'd20, 8'hF0); loadA(8'hFF);
    issue(13'h380 | 6'd20, "R3 setup");
    loadA(8'h3C);
    issue(13'h200 | 6'd20, "R5");
    issue(13'h2C0 | 6'd20, "R5");
    issue(13'h300 | 6'd20, "R5");
    issue(13'h340 | 6'd20, "R5");
    issue(13'h280 | 6'd21, "R5");
    chk("R5", "AND with zero reg", {7'b0, flagZ}, 8'h01);
  endtask

  task automatic t_move();
    loadReg(6'd30, 8'h00); loadReg(6'd31, 8'hA5);
    issue(13'h400 | 6'd31, "R6");
    issue(13'h440 | 6'd30, "R6");
    issue(13'h480 | 6'd31, "R6");
    chk("R6", "COMA 0xA5", accOut, 8'h5A);
    issue(13'h4C0 | 6'd31, "R6");
    chk("R6", "COM 0xA5", dbgData, 8'h5A);
    loadReg(6'd32, 8'hFF);
    issue(13'h4C0 | 6'd32, "R6");
  endtask

  task automatic t_incdec();
    loadReg(6'd40, 8'hFF);
    issue(13'h540 | 6'd40, "R7");
    chk("R7", "INC 0xFF", {dbgData[6:0], flagZ}, 8'h01);
    issue(13'h1C0 | 6'd40, "R7");
    chk("R7", "DEC 0x00", dbgData, 8'hFF);
    issue(13'h180 | 6'd40, "R7");
    issue(13'h500 | 6'd40, "R7");
  endtask

  task automatic t_clr();
    loadA(8'h77);
    issue(13'h040 | 6'd50, "R8");
    chk("R8", "MOV R,A", dbgData, 8'h77);
    issue(13'h0C0 | 6'd50, "R8");
    issue(13'h080, "R8");
  endtask

  task automatic t_daa();
    loadReg(6'd5, 8'h28); loadA(8'h19);
    issue(13'h380 | 6'd5, "R9 setup");
    issue(13'h001, "R9");
    chk("R9", "19+28 adjusted", accOut, 8'h47);
    loadReg(6'd6, 8'h99); loadA(8'h99);
    issue(13'h380 | 6'd6, "R9 setup");
    issue(13'h001, "R9");
    chk("R9", "99+99 adjusted", accOut, 8'h98);
    chk("R9", "C set", {7'b0, flagC}, 8'h01);
    loadReg(6'd7, 8'h00); loadA(8'h0A);
    issue(13'h100 | 6'd7, "R9 setup");
    loadA(8'hA3);
    issue(13'h001, "R9");
  endtask

  task automatic t_noop();
    logic [12:0] words [6];
    words = '{13'h000, 13'h002, 13'h010, 13'h020, 13'h5A0, 13'h1FFF};
    loadReg(6'd1, 8'h5C);
    foreach (words[i]) issue(words[i], "R10");
    issue(13'h380 | 6'd1, "R10", 1'b0);
    issue(13'h0C0 | 6'd1, "R10", 1'b0);
    sweepRegs("R10");
  endtask

  task automatic t_dbg();
    for (int i = 0; i < 64; i += 7) begin
      dbgAddr = 6'(i); #1;
      chk("R11", "comb read", dbgData, mRf[i]);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!doneFlag) begin
      nErrs++; nChecks++;
      $display("FAIL watchdog: actual=%h expected=%h", 8'h01, 8'h00);
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_move();
    t_incdec();
    t_clr();
    t_daa();
    t_noop();
    t_dbg();
    doneFlag = 1;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule